// File: doc/BRIEF.md
# GPIO-to-Interrupt Line Selector

The block takes the input pins of several GPIO ports and maps them onto 16 external-interrupt lines. Every line has a 4-bit port code. Line n carries pin n of the port that its code names. The input pins come in as one flat vector, and pin p of port k sits at index 16*k + p. The lines are combinational copies of the selected pin levels. Edge detection is left to the interrupt controller downstream.

The same 32-bit register bus also holds a small system-configuration register file. Each register has its own mask of writable bits. Some bits can only be cleared by software, some can only be set, and one bit ignores a write of one. A read is registered: the data appears, with a valid strobe, on the cycle after the request.

Top module: `gpio_irq_line_sel`

## Requirements
- R1: After reset every line code is 0 (port A), so each line n equals input pin n. Register reads return 0x7C000001 at offset 0x04 and zero at every other offset.
- R2: The select registers sit at offsets 0x08, 0x0C, 0x10 and 0x14. Register r holds the codes for lines 4r to 4r+3 in bits 15:0, four bits per line, with the lowest line in bits 3:0. Bits 31:16 read zero and ignore writes.
- R3: When a line's code k is below the port count (8), line n equals input pin 16*k+n. For example, writing 0x10 to offset 0x08 routes input 17 to line 1.
- R4: A pin on a port that a line does not select has no effect on that line.
- R5: A code of 8 or above selects nothing, and the line stays low.
- R6: Offset 0x00 keeps only the bits in 0x107. Offset 0x24 keeps only bits 7:0. All other bits of these two registers read zero.
- R7: At offset 0x04 the writable bits are 0xFCFF0101. Bit 0 is clear-only: it resets to 1, a write of 0 clears it, and a later write of 1 does not set it again.
- R8: At offset 0x1C, bits 3:0 are set-only, and a write of 1 to bit 8 leaves it reading 0. Offsets 0x20 and 0x28 are set-only over all 32 bits. Offset 0x18 reads zero.
- R9: A read request (select high, write low) gives read-valid and the data on the next cycle. Read-valid is low in every other cycle. An unmapped offset reads zero.
- R10: A select write takes effect at the clock edge that accepts it. Before that edge the line follows the old port, and from that edge on it follows the new port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| pin_in | input | 128 | GPIO pins, index 16*port+pin |
| irq_line | output | 16 | Interrupt lines to the controller |

## Verification
Two things can happen in the same cycle: a select register is rewritten, and the pins of the old port and the new port change. The bench drives both on one falling edge. It checks the line before the accepting rising edge, where the line must still follow the old port. It checks the line again after that edge, where it must follow the new port. It then toggles each port's pin in turn, to show that only the newly selected port drives the line.

// File: rtl/girq_pkg.sv
package girq_pkg;
  localparam int DW = 32;
  // word indices (byte offset / 4)
  localparam int WI_MAP   = 0;
  localparam int WI_SYS   = 1;
  localparam int WI_SEL0  = 2;
  localparam int WI_STAT  = 6;
  localparam int WI_SEC   = 7;
  localparam int WI_LOCKA = 8;
  localparam int WI_KEY   = 9;
  localparam int WI_LOCKB = 10;

  localparam logic [DW-1:0] MAP_MASK  = 32'h0000_0107;
  localparam logic [DW-1:0] SYS_MASK  = 32'hFCFF_0101;
  localparam logic [DW-1:0] SYS_RST   = 32'h7C00_0001;
  localparam logic [DW-1:0] KEY_MASK  = 32'h0000_00FF;
  localparam logic [DW-1:0] SEC_SET   = 32'h0000_000F;
endpackage

// File: rtl/girq_sel_regs.sv
module girq_sel_regs #(
  parameter int LINES = 16,
  parameter int SEL_W = 4,
  parameter int WA_W  = 4,
  parameter int BASE  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [WA_W-1:0]        waddr,
  input  logic [15:0]            wdata,
  output logic [LINES*SEL_W-1:0] sel_flat,
  output logic [31:0]            rd_word
);
  localparam int FIELDS = 16 / SEL_W;
  localparam int NREGS  = LINES / FIELDS;
  localparam int RW     = FIELDS * SEL_W;

  logic [RW-1:0] word_q [NREGS];
  logic [NREGS-1:0] hit;

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    assign hit[r] = (waddr == WA_W'(BASE + r));
    always_ff @(posedge clk) begin
      if (rst)                word_q[r] <= '0;
      else if (wr_en && hit[r]) word_q[r] <= wdata[RW-1:0];
    end
    assign sel_flat[r*RW +: RW] = word_q[r];
  end

  always_comb begin
    rd_word = '0;
    for (int r = 0; r < NREGS; r++)
      if (hit[r]) rd_word[RW-1:0] = word_q[r];
  end
endmodule

// File: rtl/girq_cfg_regs.sv
module girq_cfg_regs
  import girq_pkg::*;
#(
  parameter int WA_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WA_W-1:0] waddr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rd_word,
  output logic            sys_keep_bit,
  output logic [DW-1:0]   lock_a,
  output logic [DW-1:0]   lock_b
);
  logic [DW-1:0] map_q, sys_q, sec_q, key_q, la_q, lb_q;

  function automatic logic at(input logic [WA_W-1:0] a, input int idx);
    return a == WA_W'(idx);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
      sys_q <= SYS_RST;
      sec_q <= '0;
      key_q <= '0;
      la_q  <= '0;
      lb_q  <= '0;
    end else if (wr_en) begin
      if (at(waddr, WI_MAP))   map_q <= wdata & MAP_MASK;
      if (at(waddr, WI_SYS))   sys_q <= (wdata & SYS_MASK & ~DW'(1))
                                        | {{(DW-1){1'b0}}, sys_q[0] & wdata[0]};
      if (at(waddr, WI_SEC))   sec_q <= sec_q | (wdata & SEC_SET);
      if (at(waddr, WI_KEY))   key_q <= wdata & KEY_MASK;
      if (at(waddr, WI_LOCKA)) la_q  <= la_q | wdata;
      if (at(waddr, WI_LOCKB)) lb_q  <= lb_q | wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (at(waddr, WI_MAP))   rd_word = map_q;
    if (at(waddr, WI_SYS))   rd_word = sys_q;
    if (at(waddr, WI_SEC))   rd_word = sec_q;
    if (at(waddr, WI_KEY))   rd_word = key_q;
    if (at(waddr, WI_LOCKA)) rd_word = la_q;
    if (at(waddr, WI_LOCKB)) rd_word = lb_q;
  end

  assign sys_keep_bit = sys_q[0];
  assign lock_a = la_q;
  assign lock_b = lb_q;
endmodule

// File: rtl/girq_line_mux.sv
module girq_line_mux #(
  parameter int NUM_PORTS = 8,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input  logic [NUM_PORTS*LINES-1:0] pins,
  input  logic [LINES*SEL_W-1:0]     sel_flat,
  output logic [LINES-1:0]           lines
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [SEL_W-1:0] code;
    assign code = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      lines[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (code == SEL_W'(p)) lines[n] = pins[p*LINES + n];
    end
  end
endmodule

// File: rtl/gpio_irq_line_sel.sv
module gpio_irq_line_sel
  import girq_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DW-1:0]              bus_wdata,
  output logic [DW-1:0]              bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NUM_PORTS*LINES-1:0] pin_in,
  output logic [LINES-1:0]           irq_line
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0]        waddr;
  logic                   wr_en, rd_en;
  logic [LINES*SEL_W-1:0] sel_flat;
  logic [DW-1:0]          sel_word, cfg_word;
  logic                   sys_keep_bit;
  logic [DW-1:0]          lock_a, lock_b;
  logic [1:0]             byte_off;

  assign waddr    = bus_addr[ADDR_W-1:2];
  assign byte_off = bus_addr[1:0];
  assign wr_en    = bus_sel && bus_wr && (byte_off == 2'b00);
  assign rd_en    = bus_sel && !bus_wr;

  girq_sel_regs #(.LINES(LINES), .SEL_W(SEL_W), .WA_W(WA_W), .BASE(WI_SEL0)) u_sel (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr),
    .wdata(bus_wdata[15:0]), .sel_flat(sel_flat), .rd_word(sel_word));

  girq_cfg_regs #(.WA_W(WA_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .waddr(waddr), .wdata(bus_wdata),
    .rd_word(cfg_word), .sys_keep_bit(sys_keep_bit),
    .lock_a(lock_a), .lock_b(lock_b));

  girq_line_mux #(.NUM_PORTS(NUM_PORTS), .LINES(LINES), .SEL_W(SEL_W)) u_mux (
    .pins(pin_in), .sel_flat(sel_flat), .lines(irq_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_en;
      bus_rdata  <= rd_en ? (sel_word | cfg_word) : '0;
    end
  end
endmodule

// File: rtl/gpio_irq_line_sel_chk.sv
module gpio_irq_line_sel_chk #(
  parameter int NUM_PORTS = 8,
  parameter int LINES     = 16,
  parameter int SEL_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic                       bus_rvalid,
  input logic [NUM_PORTS*LINES-1:0] pin_in,
  input logic [LINES-1:0]           irq_line,
  input logic [LINES*SEL_W-1:0]     sel_flat,
  input logic                       sys_keep_bit,
  input logic [31:0]                lock_a,
  input logic [31:0]                lock_b
);
  a_r1_reset_port_a: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> irq_line == pin_in[LINES-1:0]);

  for (genvar n = 0; n < LINES; n++) begin : g_chk
    a_r5_dead_code_low: assert property (@(posedge clk) disable iff (rst)
      (sel_flat[n*SEL_W +: SEL_W] >= SEL_W'(NUM_PORTS)) |-> !irq_line[n]);
  end

  a_r7_clear_only: assert property (@(posedge clk) disable iff (rst)
    !$rose(sys_keep_bit));

  a_r8_set_only_a: assert property (@(posedge clk) disable iff (rst)
    !(|($past(lock_a) & ~lock_a)));

  a_r8_set_only_b: assert property (@(posedge clk) disable iff (rst)
    !(|($past(lock_b) & ~lock_b)));

  a_r9_read_valid: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> !bus_rvalid);
endmodule

bind gpio_irq_line_sel gpio_irq_line_sel_chk #(
  .NUM_PORTS(NUM_PORTS), .LINES(LINES), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_rvalid(bus_rvalid), .pin_in(pin_in), .irq_line(irq_line),
  .sel_flat(sel_flat), .sys_keep_bit(sys_keep_bit),
  .lock_a(lock_a), .lock_b(lock_b));

// File: tb/tb_gpio_irq_line_sel.sv
module tb_gpio_irq_line_sel;
  logic         clk = 0;
  logic         rst = 1;
  logic         bus_sel = 0, bus_wr = 0;
  logic [5:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;
  logic [127:0] pins = '0;
  logic [15:0]  irq_line;

  int vectors = 0, errors = 0;
  int codes [16];

  always #2 clk = ~clk;

  gpio_irq_line_sel dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pins), .irq_line(irq_line));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if (a >= 6'h08 && a <= 6'h14)
      for (int k = 0; k < 4; k++) codes[(a - 6'h08) + k] = int'(d[k*4 +: 4]);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(tag, d, exp);
  endtask

  function automatic logic [15:0] exp_lines(input logic [127:0] p);
    logic [15:0] e = '0;
    for (int n = 0; n < 16; n++)
      if (codes[n] < 8) e[n] = p[codes[n]*16 + n];
    return e;
  endfunction

  task automatic line_chk(input string tag);
    #1;
    chk(tag, {16'h0, irq_line}, {16'h0, exp_lines(pins)});
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    for (int n = 0; n < 16; n++) codes[n] = 0;
    for (int a = 0; a <= 'h28; a += 4)
      rd_chk("R1 reset value", 6'(a), (a == 4) ? 32'h7C000001 : 32'h0);
    pins = {$urandom, $urandom, $urandom, $urandom};
    line_chk("R1 default port A");
    rd(6'h2C, d, v);
    chk("R9 rvalid on response", {31'h0, v}, 32'h1);
    chk("R9 unmapped reads zero", d, 32'h0);
    @(negedge clk);
    chk("R9 rvalid drops", {31'h0, bus_rvalid}, 32'h0);
  endtask

  task automatic t_layout;
    wr(6'h08, 32'hFFFF_0010);
    rd_chk("R2 upper bits ignored", 6'h08, 32'h0000_0010);
    pins = '0; pins[17] = 1'b1;
    line_chk("R3 input 17 to line 1");
    chk("R3 line1 high", {31'h0, irq_line[1]}, 32'h1);
    pins = '0; pins[1] = 1'b1;
    line_chk("R4 port A pin1 ignored");
    chk("R4 line1 low", {31'h0, irq_line[1]}, 32'h0);
    wr(6'h14, 32'h0000_4321);
    rd_chk("R2 last select reg", 6'h14, 32'h0000_4321);
    wr(6'h08, 0); wr(6'h14, 0);
  endtask

  task automatic t_all_ports;
    for (int p = 0; p < 8; p++) begin
      logic [31:0] rep = {16'h0, {4{4'(p)}}};
      for (int r = 0; r < 4; r++) wr(6'(8 + 4*r), rep);
      for (int k = 0; k < 3; k++) begin
        pins = {$urandom, $urandom, $urandom, $urandom};
        line_chk("R3 port sweep");
        pins[p*16 +: 16] = ~pins[p*16 +: 16];
        line_chk("R3 port sweep inverted");
      end
      pins[p*16 +: 16] = '0;
      pins = pins | ~(128'hFFFF << (p*16));
      line_chk("R4 other ports high");
    end
    for (int r = 0; r < 4; r++) wr(6'(8 + 4*r), 32'h0);
  endtask

  task automatic t_bad_code;
    wr(6'h08, 32'h0000_F98A);
    wr(6'h0C, 32'h0000_0008);
    pins = '1;
    #1;
    chk("R5 dead codes low", {16'h0, irq_line}, 32'h0000_FFE0);
    wr(6'h08, 0); wr(6'h0C, 0);
  endtask

  task automatic t_same_cycle;
    pins = '0; pins[0] = 1'b1;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 6'h08; bus_wdata = 32'h2;
    pins[0] = 1'b1; pins[32] = 1'b0;
    #1;
    chk("R10 old port before edge", {31'h0, irq_line[0]}, 32'h1);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    codes[0] = 2;
    #1;
    chk("R10 new port after edge", {31'h0, irq_line[0]}, 32'h0);
    pins[32] = 1'b1; pins[0] = 1'b0;
    line_chk("R10 follows port C");
    chk("R10 line0 high", {31'h0, irq_line[0]}, 32'h1);
    wr(6'h08, 0);
  endtask

  task automatic t_masks;
    wr(6'h00, 32'hFFFF_FFFF);
    rd_chk("R6 map mask", 6'h00, 32'h0000_0107);
    wr(6'h00, 32'h0);
    rd_chk("R6 map clear", 6'h00, 32'h0);
    wr(6'h24, 32'hFFFF_FFFF);
    rd_chk("R6 key mask", 6'h24, 32'h0000_00FF);
    wr(6'h24, 32'h0);
    rd_chk("R6 key clear", 6'h24, 32'h0);
  endtask

  task automatic t_sys;
    wr(6'h04, 32'hFFFF_FFFF);
    rd_chk("R7 writable mask", 6'h04, 32'hFCFF_0101);
    wr(6'h04, 32'h0);
    rd_chk("R7 bit0 cleared", 6'h04, 32'h0);
    wr(6'h04, 32'hFFFF_FFFF);
    rd_chk("R7 bit0 stays clear", 6'h04, 32'hFCFF_0100);
  endtask

  task automatic t_set_only;
    wr(6'h1C, 32'h0000_0100);
    rd_chk("R8 bit8 reads zero", 6'h1C, 32'h0);
    wr(6'h1C, 32'h0000_0105);
    wr(6'h1C, 32'h0000_000A);
    rd_chk("R8 set-only nibble", 6'h1C, 32'h0000_000F);
    wr(6'h1C, 32'h0);
    rd_chk("R8 nibble not cleared", 6'h1C, 32'h0000_000F);
    wr(6'h20, 32'hA5A5_A5A5);
    wr(6'h20, 32'h5A5A_0000);
    rd_chk("R8 lock A accumulates", 6'h20, 32'hFFFF_A5A5);
    wr(6'h20, 32'h0);
    rd_chk("R8 lock A holds", 6'h20, 32'hFFFF_A5A5);
    wr(6'h28, 32'h8000_0001);
    wr(6'h28, 32'h0);
    rd_chk("R8 lock B holds", 6'h28, 32'h8000_0001);
    wr(6'h18, 32'hFFFF_FFFF);
    rd_chk("R8 status reads zero", 6'h18, 32'h0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 0;
    t_reset();
    t_layout();
    t_all_ports();
    t_bad_code();
    t_same_cycle();
    t_masks();
    t_sys();
    t_set_only();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule